// File: doc/BRIEF.md
# Precise Exception Pipeline Controller

This block is the exception-tracking spine of a five-stage in-order pipeline (fetch, decode, execute, memory, writeback). Each of the first four stages is modelled as a register holding a valid bit, the instruction's PC and a cause code. Any stage may report a fault for the instruction it currently holds. That fault is not acted on where it is raised. It is recorded in the instruction's own cause field and carried forward with it.

A single commit point sits at the end of the memory stage. When a valid instruction leaves the memory stage with a non-empty cause, the controller takes the trap. It captures that instruction's PC and cause, signals a redirect to a fixed handler address, and clears the valid bits of every younger instruction in the same edge. An external interrupt request is latched and then injected at fetch as a no-op that already carries an interrupt cause. From there it travels like any other faulting instruction. A stall input freezes the four tracked stages and lets a bubble drain into writeback. A trap overrides the stall.

Top module: `pexc_ctrl`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, `stage_valid_o` is 0, `wb_en_o`, `trap_o` and `mem_we_ok_o` are 0, `epc_o` is 0 and `cause_o` is 0.
- R2: With no stall and no fault, an instruction presented with `fetch_valid_i`=1 at a clock edge enters fetch (bit 0 of `stage_valid_o`). It then moves one stage per edge (bit 1 decode, bit 2 execute, bit 3 memory). After the fifth edge it shows `wb_en_o`=1 with `wb_pc_o` equal to its PC.
- R3: A fault reported by the fetch, decode or execute stage does not raise `trap_o` immediately. `trap_o` is 1 only in a cycle where the memory stage holds a valid instruction whose carried cause, or the memory fault input, is set.
- R4: In a trap cycle `handler_pc_o` gives the handler address (parameter `HANDLER_PC`). After that edge `epc_o` holds the PC of the instruction that was in the memory stage.
- R5: Cause codes: 0 none, 1 fetch fault, 2 illegal opcode (decode), 3 arithmetic overflow (execute), 4 data access fault (memory), 5 external interrupt. When one instruction collects faults in several stages, the first one recorded is kept.
- R6: After a trap edge, bits 3..0 of `stage_valid_o` are all 0 and `wb_en_o` is 0, so the faulting instruction never writes back. Any instruction fetched in the trap cycle is dropped.
- R7: `mem_we_ok_o` is 1 only when the memory stage holds a valid instruction with no cause and no memory fault, and there is no stall. An older instruction already in writeback still shows `wb_en_o`=1 in the trap cycle.
- R8: When several in-flight instructions carry faults, the oldest one (furthest down the pipeline) is the one trapped. The younger faults are discarded and raise no later trap.
- R9: A one-cycle pulse on `irq_i` is held pending. At the next edge with no stall and no trap, a valid entry with PC `fetch_pc_i` and cause 5 is loaded into fetch in place of the fetched instruction. It traps when it reaches the memory stage.
- R10: With `stall_i`=1 and no trap, `stage_valid_o` is unchanged across the edge, fault inputs for the held stages are not recorded, and `wb_en_o` is 0 after the edge. A trap in a stalled cycle is still taken and flushes.
- R11: `epc_o` and `cause_o` change only at a trap edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| stall_i | input | 1 | Freeze fetch..memory stages |
| irq_i | input | 1 | External interrupt request pulse |
| fetch_valid_i | input | 1 | A fetched instruction is offered this cycle |
| fetch_pc_i | input | AW | PC of the instruction being fetched |
| fetch_fault_i | input | 1 | Fault on the instruction held in fetch |
| decode_fault_i | input | 1 | Illegal opcode for the instruction in decode |
| exec_fault_i | input | 1 | Overflow for the instruction in execute |
| mem_fault_i | input | 1 | Data access fault for the instruction in memory |
| stage_valid_o | output | 4 | Valid bits: 0 fetch, 1 decode, 2 execute, 3 memory |
| mem_we_ok_o | output | 1 | Memory-stage store may be performed |
| wb_en_o | output | 1 | Writeback-stage instruction may write registers |
| wb_pc_o | output | AW | PC of the writeback-stage instruction |
| trap_o | output | 1 | Trap taken this cycle, redirect fetch |
| handler_pc_o | output | AW | Handler vector address |
| epc_o | output | AW | Saved PC of the trapped instruction |
| cause_o | output | 3 | Saved cause code |

## Verification
A wrong cause or PC in any stage register stays hidden until that instruction reaches the memory stage. It then shows up as a wrong `epc_o` or `cause_o` one edge after `trap_o`, so the bench must compare the saved values after every trap, not only in the directed cases. A missed flush appears one edge after the trap as a set bit in `stage_valid_o`, and a few edges later as a spurious `wb_en_o` or a second trap from a younger instruction. A stall that leaks shows up within one cycle as a changed valid pattern or a writeback during the freeze.

// File: rtl/pexc_pkg.sv
package pexc_pkg;

  typedef enum logic [2:0] {
    CAUSE_NONE    = 3'd0,
    CAUSE_IFETCH  = 3'd1,
    CAUSE_ILLEGAL = 3'd2,
    CAUSE_OVFL    = 3'd3,
    CAUSE_DMEM    = 3'd4,
    CAUSE_IRQ     = 3'd5
  } cause_e;

  // Cause raised by the stage at a given position (0 fetch .. 3 memory).
  function automatic cause_e stage_cause(int unsigned idx);
    case (idx)
      0:       return CAUSE_IFETCH;
      1:       return CAUSE_ILLEGAL;
      2:       return CAUSE_OVFL;
      default: return CAUSE_DMEM;
    endcase
  endfunction

  // First recorded cause is sticky; a new fault only counts on a valid entry.
  function automatic cause_e carry_cause(cause_e held, logic raised,
                                         logic valid, int unsigned idx);
    if (held != CAUSE_NONE) return held;
    if (raised && valid)    return stage_cause(idx);
    return CAUSE_NONE;
  endfunction

endpackage

// File: rtl/pexc_stage.sv
module pexc_stage
  import pexc_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          hold,
  input  logic          flush,
  input  logic          d_valid,
  input  logic [AW-1:0] d_pc,
  input  cause_e        d_cause,
  output logic          q_valid,
  output logic [AW-1:0] q_pc,
  output cause_e        q_cause
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      q_valid <= 1'b0;
      q_pc    <= '0;
      q_cause <= CAUSE_NONE;
    end else if (flush) begin
      q_valid <= 1'b0;
      q_cause <= CAUSE_NONE;
    end else if (!hold) begin
      q_valid <= d_valid;
      q_pc    <= d_pc;
      q_cause <= d_valid ? d_cause : CAUSE_NONE;
    end
  end

endmodule

// File: rtl/pexc_inject.sv
module pexc_inject
  import pexc_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          irq_i,
  input  logic          stall_i,
  input  logic          trap_i,
  input  logic          fetch_valid_i,
  input  logic [AW-1:0] fetch_pc_i,
  output logic          e_valid,
  output logic [AW-1:0] e_pc,
  output cause_e        e_cause,
  output logic          inject_o
);

  logic pend_q;

  assign inject_o = pend_q && !stall_i && !trap_i;

  always_ff @(posedge clk) begin
    if (!rst_n) pend_q <= 1'b0;
    else        pend_q <= irq_i || (pend_q && !inject_o);
  end

  always_comb begin
    e_pc = fetch_pc_i;
    if (inject_o) begin
      e_valid = 1'b1;
      e_cause = CAUSE_IRQ;
    end else begin
      e_valid = fetch_valid_i;
      e_cause = CAUSE_NONE;
    end
  end

endmodule

// File: rtl/pexc_commit.sv
module pexc_commit
  import pexc_pkg::*;
#(
  parameter int          AW         = 32,
  parameter logic [AW-1:0] HANDLER_PC = '0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          stall_i,
  input  logic          m_valid,
  input  logic [AW-1:0] m_pc,
  input  cause_e        m_cause,
  output logic          trap_o,
  output logic [AW-1:0] handler_pc_o,
  output logic [AW-1:0] epc_o,
  output cause_e        cause_o,
  output logic          mem_we_ok_o,
  output logic          wb_en_o,
  output logic [AW-1:0] wb_pc_o
);

  logic clean;

  assign clean        = m_valid && (m_cause == CAUSE_NONE);
  assign trap_o       = m_valid && (m_cause != CAUSE_NONE);
  assign mem_we_ok_o  = clean && !stall_i;
  assign handler_pc_o = HANDLER_PC;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      epc_o   <= '0;
      cause_o <= CAUSE_NONE;
    end else if (trap_o) begin
      epc_o   <= m_pc;
      cause_o <= m_cause;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wb_en_o <= 1'b0;
      wb_pc_o <= '0;
    end else begin
      wb_en_o <= clean && !stall_i;
      if (clean && !stall_i) wb_pc_o <= m_pc;
    end
  end

endmodule

// File: rtl/pexc_ctrl.sv
module pexc_ctrl
  import pexc_pkg::*;
#(
  parameter int            AW         = 32,
  parameter logic [AW-1:0] HANDLER_PC = 'h80
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          stall_i,
  input  logic          irq_i,
  input  logic          fetch_valid_i,
  input  logic [AW-1:0] fetch_pc_i,
  input  logic          fetch_fault_i,
  input  logic          decode_fault_i,
  input  logic          exec_fault_i,
  input  logic          mem_fault_i,
  output logic [3:0]    stage_valid_o,
  output logic          mem_we_ok_o,
  output logic          wb_en_o,
  output logic [AW-1:0] wb_pc_o,
  output logic          trap_o,
  output logic [AW-1:0] handler_pc_o,
  output logic [AW-1:0] epc_o,
  output logic [2:0]    cause_o
);

  localparam int NSTG = 4;
  localparam int LAST = NSTG - 1;

  logic [NSTG-1:0] flt;
  logic            stg_valid [NSTG];
  logic [AW-1:0]   stg_pc    [NSTG];
  cause_e          stg_cause [NSTG];
  cause_e          exit_cause[NSTG];

  logic          ent_valid;
  logic [AW-1:0] ent_pc;
  cause_e        ent_cause;

  // Named internal events for the checker.
  logic          trap_w;
  logic          inject_w;
  logic [AW-1:0] commit_pc;
  cause_e        commit_cause;
  cause_e        saved_cause;

  assign flt = {mem_fault_i, exec_fault_i, decode_fault_i, fetch_fault_i};

  pexc_inject #(.AW(AW)) u_inject (
    .clk           (clk),
    .rst_n         (rst_n),
    .irq_i         (irq_i),
    .stall_i       (stall_i),
    .trap_i        (trap_w),
    .fetch_valid_i (fetch_valid_i),
    .fetch_pc_i    (fetch_pc_i),
    .e_valid       (ent_valid),
    .e_pc          (ent_pc),
    .e_cause       (ent_cause),
    .inject_o      (inject_w)
  );

  for (genvar i = 0; i < NSTG; i++) begin : g_stage
    logic          dv;
    logic [AW-1:0] dp;
    cause_e        dc;

    if (i == 0) begin : g_head
      assign dv = ent_valid;
      assign dp = ent_pc;
      assign dc = ent_cause;
    end else begin : g_body
      assign dv = stg_valid[i-1];
      assign dp = stg_pc[i-1];
      assign dc = exit_cause[i-1];
    end

    pexc_stage #(.AW(AW)) u_stg (
      .clk     (clk),
      .rst_n   (rst_n),
      .hold    (stall_i),
      .flush   (trap_w),
      .d_valid (dv),
      .d_pc    (dp),
      .d_cause (dc),
      .q_valid (stg_valid[i]),
      .q_pc    (stg_pc[i]),
      .q_cause (stg_cause[i])
    );

    assign exit_cause[i]    = carry_cause(stg_cause[i], flt[i], stg_valid[i], i);
    assign stage_valid_o[i] = stg_valid[i];
  end

  assign commit_pc    = stg_pc[LAST];
  assign commit_cause = exit_cause[LAST];

  pexc_commit #(.AW(AW), .HANDLER_PC(HANDLER_PC)) u_commit (
    .clk          (clk),
    .rst_n        (rst_n),
    .stall_i      (stall_i),
    .m_valid      (stg_valid[LAST]),
    .m_pc         (commit_pc),
    .m_cause      (commit_cause),
    .trap_o       (trap_w),
    .handler_pc_o (handler_pc_o),
    .epc_o        (epc_o),
    .cause_o      (saved_cause),
    .mem_we_ok_o  (mem_we_ok_o),
    .wb_en_o      (wb_en_o),
    .wb_pc_o      (wb_pc_o)
  );

  assign trap_o  = trap_w;
  assign cause_o = saved_cause;

endmodule

// File: rtl/pexc_ctrl_chk.sv
module pexc_ctrl_chk #(
  parameter int AW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          stall_i,
  input logic          trap_w,
  input logic          inject_w,
  input logic [3:0]    stage_valid_o,
  input logic          wb_en_o,
  input logic          mem_we_ok_o,
  input logic [AW-1:0] epc_o,
  input logic [2:0]    cause_o,
  input logic [AW-1:0] commit_pc
);

  AST_TRAP_AT_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
    trap_w |-> stage_valid_o[3]); // R3

  AST_EPC_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
    trap_w |=> (epc_o == $past(commit_pc)) && (cause_o != 3'd0)); // R4

  AST_FLUSH_ALL: assert property (@(posedge clk) disable iff (!rst_n)
    trap_w |=> (stage_valid_o == 4'b0000) && !wb_en_o); // R6

  AST_NO_STORE_ON_TRAP: assert property (@(posedge clk) disable iff (!rst_n)
    trap_w |-> !mem_we_ok_o); // R7

  AST_INJECT_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
    inject_w |=> stage_valid_o[0]); // R9

  AST_STALL_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
    (stall_i && !trap_w) |=> $stable(stage_valid_o) && !wb_en_o); // R10

  AST_EPC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !trap_w |=> $stable(epc_o) && $stable(cause_o)); // R11

endmodule

bind pexc_ctrl pexc_ctrl_chk #(.AW(AW)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .stall_i       (stall_i),
  .trap_w        (trap_w),
  .inject_w      (inject_w),
  .stage_valid_o (stage_valid_o),
  .wb_en_o       (wb_en_o),
  .mem_we_ok_o   (mem_we_ok_o),
  .epc_o         (epc_o),
  .cause_o       (cause_o),
  .commit_pc     (commit_pc)
);

// File: tb/sim_pexc_ctrl.sv
module sim_pexc_ctrl;

  localparam logic [31:0] VEC = 32'h80;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        stall_i = 1'b0, irq_i = 1'b0, fetch_valid_i = 1'b0;
  logic [31:0] fetch_pc_i = '0;
  logic        fetch_fault_i = 1'b0, decode_fault_i = 1'b0;
  logic        exec_fault_i = 1'b0, mem_fault_i = 1'b0;
  logic [3:0]  stage_valid_o;
  logic        mem_we_ok_o, wb_en_o, trap_o;
  logic [31:0] wb_pc_o, handler_pc_o, epc_o;
  logic [2:0]  cause_o;

  always #4 clk = ~clk;  // 125 MHz

  pexc_ctrl #(.AW(32), .HANDLER_PC(VEC)) u0 (
    .clk(clk), .rst_n(rst_n), .stall_i(stall_i), .irq_i(irq_i),
    .fetch_valid_i(fetch_valid_i), .fetch_pc_i(fetch_pc_i),
    .fetch_fault_i(fetch_fault_i), .decode_fault_i(decode_fault_i),
    .exec_fault_i(exec_fault_i), .mem_fault_i(mem_fault_i),
    .stage_valid_o(stage_valid_o), .mem_we_ok_o(mem_we_ok_o),
    .wb_en_o(wb_en_o), .wb_pc_o(wb_pc_o), .trap_o(trap_o),
    .handler_pc_o(handler_pc_o), .epc_o(epc_o), .cause_o(cause_o)
  );

  int checks = 0;
  int fails  = 0;

  // Reference state: slot 0 is the youngest tracked instruction.
  bit          r_v [4];
  logic [31:0] r_pc[4];
  int          r_c [4];
  bit          r_wv, r_pend;
  logic [31:0] r_wpc, r_epc;
  int          r_cause;

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic bit flt_of(int s);
    case (s)
      0: return fetch_fault_i;
      1: return decode_fault_i;
      2: return exec_fault_i;
      default: return mem_fault_i;
    endcase
  endfunction

  // R5: first recorded cause wins; stage s reports code s+1.
  function automatic int leave_code(int s);
    if (r_c[s] != 0) return r_c[s];
    if (r_v[s] && flt_of(s)) return s + 1;
    return 0;
  endfunction

  function automatic bit exp_trap();
    return r_v[3] && (leave_code(3) != 0);
  endfunction

  task automatic model_reset();
    for (int s = 0; s < 4; s++) begin r_v[s] = 0; r_pc[s] = '0; r_c[s] = 0; end
    r_wv = 0; r_pend = 0; r_wpc = '0; r_epc = '0; r_cause = 0;
  endtask

  task automatic compare_all();
    chk("R10 stage valid", {28'd0, stage_valid_o}, {28'd0, r_v[3], r_v[2], r_v[1], r_v[0]});
    chk("R3 trap", {31'd0, trap_o}, {31'd0, exp_trap()});
    chk("R4 handler", handler_pc_o, VEC);
    chk("R7 store ok", {31'd0, mem_we_ok_o},
        {31'd0, r_v[3] && leave_code(3) == 0 && !stall_i});
    chk("R2 wb en", {31'd0, wb_en_o}, {31'd0, r_wv});
    if (r_wv) chk("R2 wb pc", wb_pc_o, r_wpc);
    chk("R11 epc", epc_o, r_epc);
    chk("R5 cause", {29'd0, cause_o}, r_cause);
  endtask

  task automatic model_step();
    int  lc[4];
    bit  tr, inj;
    for (int s = 0; s < 4; s++) lc[s] = leave_code(s);
    tr  = r_v[3] && lc[3] != 0;
    inj = r_pend && !stall_i && !tr;
    r_wv = !tr && !stall_i && r_v[3];
    if (r_wv) r_wpc = r_pc[3];
    if (tr) begin
      r_epc = r_pc[3]; r_cause = lc[3];
      for (int s = 0; s < 4; s++) begin r_v[s] = 0; r_c[s] = 0; end
    end else if (!stall_i) begin
      for (int s = 3; s > 0; s--) begin
        r_v[s] = r_v[s-1]; r_pc[s] = r_pc[s-1]; r_c[s] = r_v[s-1] ? lc[s-1] : 0;
      end
      r_v[0]  = inj ? 1'b1 : fetch_valid_i;
      r_pc[0] = fetch_pc_i;
      r_c[0]  = inj ? 5 : 0;
    end
    r_pend = irq_i || (r_pend && !inj);
  endtask

  // Drive at the falling edge, compare, then let the rising edge happen.
  task automatic drive(bit st, bit iq, bit v, logic [31:0] pc, bit [3:0] f);
    @(negedge clk);
    stall_i = st; irq_i = iq; fetch_valid_i = v; fetch_pc_i = pc;
    fetch_fault_i = f[0]; decode_fault_i = f[1]; exec_fault_i = f[2]; mem_fault_i = f[3];
    #1;
    if (rst_n) compare_all();
  endtask

  task automatic advance();
    @(posedge clk);
    if (rst_n) model_step(); else model_reset();
  endtask

  task automatic cyc(bit st, bit iq, bit v, logic [31:0] pc, bit [3:0] f);
    drive(st, iq, v, pc, f);
    advance();
  endtask

  task automatic idle(int n);
    for (int k = 0; k < n; k++) cyc(0, 0, 0, 32'h0, 4'h0);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    cyc(0, 0, 0, 0, 0);
    drive(0, 0, 0, 0, 0);
    chk("R1 valid in reset", {28'd0, stage_valid_o}, 32'd0);
    chk("R1 wb in reset", {31'd0, wb_en_o}, 32'd0);
    advance();
    rst_n = 1'b1;
    model_reset();
  endtask

  initial begin
    #1_000_000;
    fails++; checks++;
    $display("FAIL watchdog actual=running expected=done");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_2024));
    do_reset();
    drive(0, 0, 0, 0, 0);
    chk("R1 trap", {31'd0, trap_o}, 32'd0);
    chk("R1 epc", epc_o, 32'd0);
    chk("R1 cause", {29'd0, cause_o}, 32'd0);
    chk("R1 store", {31'd0, mem_we_ok_o}, 32'd0);
    advance();

    // R2: one instruction walks to writeback in five edges.
    cyc(0, 0, 1, 32'h100, 0);
    idle(4);
    drive(0, 0, 0, 0, 0);
    chk("R2 arrives", {31'd0, wb_en_o}, 32'd1);
    chk("R2 pc", wb_pc_o, 32'h100);
    advance();

    // R8: older overflow beats younger illegal opcode.
    cyc(0, 0, 1, 32'h40, 0);
    cyc(0, 0, 1, 32'h44, 0);
    idle(1);
    cyc(0, 0, 0, 0, 4'b0110);
    drive(0, 0, 1, 32'h48, 0);
    chk("R3 trap at commit", {31'd0, trap_o}, 32'd1);
    advance();
    drive(0, 0, 0, 0, 0);
    chk("R8 epc oldest", epc_o, 32'h40);
    chk("R5 overflow code", {29'd0, cause_o}, 32'd3);
    chk("R6 flushed", {28'd0, stage_valid_o}, 32'd0);
    advance();
    for (int k = 0; k < 5; k++) begin
      drive(0, 0, 0, 0, 0);
      chk("R8 no second trap", {31'd0, trap_o}, 32'd0);
      advance();
    end

    // R5: fetch fault stays recorded over a later data fault.
    cyc(0, 0, 1, 32'h500, 0);
    cyc(0, 0, 0, 0, 4'b0001);
    idle(2);
    drive(0, 0, 0, 0, 4'b1000);
    chk("R5 trap", {31'd0, trap_o}, 32'd1);
    advance();
    drive(0, 0, 0, 0, 0);
    chk("R5 sticky code", {29'd0, cause_o}, 32'd1);
    chk("R4 epc", epc_o, 32'h500);
    advance();

    // R9: interrupt becomes a faulting no-op at fetch.
    cyc(0, 1, 0, 0, 0);
    cyc(0, 0, 1, 32'h200, 0);
    idle(3);
    drive(0, 0, 0, 0, 0);
    chk("R9 irq trap", {31'd0, trap_o}, 32'd1);
    advance();
    drive(0, 0, 0, 0, 0);
    chk("R9 epc", epc_o, 32'h200);
    chk("R9 code", {29'd0, cause_o}, 32'd5);
    advance();

    // R10: trap during stall still flushes.
    cyc(0, 0, 1, 32'h300, 0);
    cyc(0, 0, 1, 32'h304, 0);
    idle(2);
    drive(1, 0, 0, 0, 4'b1000);
    chk("R10 trap under stall", {31'd0, trap_o}, 32'd1);
    advance();
    drive(0, 0, 0, 0, 0);
    chk("R10 flush wins", {28'd0, stage_valid_o}, 32'd0);
    chk("R5 data code", {29'd0, cause_o}, 32'd4);
    advance();

    // Random traffic against the reference model.
    for (int n = 0; n < 3000; n++) begin
      bit [3:0] f;
      for (int s = 0; s < 4; s++) f[s] = ($urandom % 40) == 0;
      cyc(($urandom % 7) == 0, ($urandom % 90) == 0, ($urandom % 5) != 0,
          {$urandom % 32'h4000, 2'b00}, f);
    end

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule